// File: doc/BRIEF.md
# Local Bus Chip-Select Read Sequencer

This block runs one asynchronous read on a local bus that carries address and data on the same wires. It serves a single bank of simple static memory. A request arrives with an address and three timing attributes for the bank: a chip-select placement code, an output-enable delay and a wait-state count. The sequencer then works through four steps:

1. It drives the address and pulses the address-latch strobe.
2. It places chip-select and output-enable.
3. It raises an internal transfer-acknowledge and captures the returned data.
4. It hands the bus back through a bus-control line, so that the next address phase can start.

Everything runs on a fast clock with `PHASES` ticks per local-bus cycle, four by default. Intervals are counted in whole bus cycles. Chip-select placement is resolved to a quarter or a half of a bus cycle. The read cycle opens when the address-latch strobe asserts and closes when bus-control returns high. Requests that arrive in between are ignored.

Top module: `lbrd_read_seq`

## Requirements
- R1: While reset is high and after it is released, `ale_n_o`, `cs_n_o`, `oe_n_o`, `ta_n_o` and `ctl_n_o` are all 1, and `ad_oe_o` and `done_o` are 0.
- R2: A request sampled high while the sequencer is idle starts a cycle at that edge. `ale_n_o` and `ctl_n_o` go to 0 from that edge, and `ale_n_o` stays 0 for exactly `PHASES` ticks.
- R3: Chip-select placement follows the 2-bit code. Codes 0 and 1 assert `cs_n_o` together with `ale_n_o`. Code 2 asserts it `PHASES/4` ticks after `ale_n_o` negates. Code 3 asserts it `PHASES/2` ticks after `ale_n_o` negates.
- R4: `oe_n_o` asserts `oed*PHASES` ticks after the chip-select placement point. The placement point is the `ale_n_o` negation, plus the delay of code 2 or 3 when one of those codes is used. From the start of the cycle until `oe_n_o` asserts, `ad_oe_o` is 1 and `ad_o` carries the latched address. From that moment until the cycle ends, `ad_oe_o` is 0.
- R5: `ta_n_o` goes to 0 for exactly one tick, after `oe_n_o` has been low for `(ws+1)*PHASES` ticks.
- R6: `ad_i` is captured on the edge at which `ta_n_o` falls. `done_o` is 1 for the single tick after the acknowledge tick, with the captured word on `rdata_o`.
- R7: `cs_n_o` and `oe_n_o` negate on the same edge, the one right after the acknowledge tick.
- R8: `ctl_n_o` returns to 1 exactly `PHASES` ticks after the strobes negate. From then on the sequencer is idle.
- R9: A request seen while `ctl_n_o` is 0, up to and including the edge on which it returns to 1, starts nothing.
- R10: The address and the three attributes are taken when the request is accepted. Changing the inputs later has no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, PHASES ticks per bus cycle |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Read request |
| addr_i | input | DW | Read address |
| csd_i | input | 2 | Chip-select placement code |
| oed_i | input | 2 | Output-enable delay in bus cycles |
| ws_i | input | 4 | Wait states in bus cycles |
| ad_o | output | DW | Shared bus value when driven |
| ad_oe_o | output | 1 | Shared bus drive enable |
| ad_i | input | DW | Shared bus value seen from the pins |
| ale_n_o | output | 1 | Address-latch strobe, active low |
| cs_n_o | output | 1 | Chip-select, active low |
| oe_n_o | output | 1 | Output-enable, active low |
| ta_n_o | output | 1 | Internal transfer-acknowledge, active low |
| ctl_n_o | output | 1 | Bus control, low during a cycle, high at turnaround |
| done_o | output | 1 | One-tick read-complete pulse |
| rdata_o | output | DW | Captured read data |

## Verification
The assertions assume two things about the inputs. Reset is applied before the first meaningful edge. `ad_i` comes only from the memory side and does not depend on the request inputs within the same tick. The bench holds to both. Its memory model puts a word on `ad_i` only while chip-select and output-enable are both low and the acknowledge has not yet fallen; at other times it shows a marker word. A capture made on the wrong edge therefore shows up as a data mismatch. Every combination of placement code, output-enable delay and wait count is swept. In each cycle the bench raises a request with a different address and different attributes while bus-control is low, and holds it through the edge on which bus-control returns high.

// File: rtl/lbrd_pkg.sv
package lbrd_pkg;

    localparam int CSD_W = 2;
    localparam int OED_W = 2;
    localparam int WS_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CSDLY,
        ST_OEDLY,
        ST_WAIT,
        ST_ACK,
        ST_TURN
    } lb_state_e;

    typedef struct packed {
        logic [CSD_W-1:0] csd;
        logic [OED_W-1:0] oed;
        logic [WS_W-1:0]  ws;
    } lb_attr_t;

    // fine chip-select delay in fast ticks after the address latch closes
    function automatic int unsigned cs_fine_ticks(logic [CSD_W-1:0] code, int unsigned ph);
        case (code)
            2'b10:   return ph / 4;
            2'b11:   return ph / 2;
            default: return 0;
        endcase
    endfunction

    // chip-select already asserted during the address phase
    function automatic logic cs_early(logic [CSD_W-1:0] code);
        return ~code[1];
    endfunction

endpackage

// File: rtl/lbrd_timer.sv
module lbrd_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    p_timer_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lbrd_fsm.sv
module lbrd_fsm
    import lbrd_pkg::*;
#(
    parameter int PHASES = 4,
    parameter int CW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  lb_attr_t      attr_in,
    input  logic          zero,
    output lb_state_e     state,
    output logic          accept,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          ale_n,
    output logic          cs_n,
    output logic          oe_n,
    output logic          ta_n,
    output logic          ctl_n
);
    localparam logic [CW-1:0] PH_C = CW'(PHASES);

    lb_state_e st_q, st_d;
    lb_attr_t  attr_q;
    logic [CW-1:0] fine_c;
    logic [CW-1:0] oed_len;
    logic [CW-1:0] ws_len;

    always_comb begin
        fine_c  = CW'(cs_fine_ticks(attr_q.csd, PHASES));
        oed_len = CW'(attr_q.oed) * PH_C;
        ws_len  = (CW'(attr_q.ws) + 1'b1) * PH_C;
    end

    assign accept = (st_q == ST_IDLE) && req;

    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        load_val = '0;
        case (st_q)
            ST_IDLE: if (req) begin
                st_d = ST_ADDR; load = 1'b1; load_val = PH_C - 1'b1;
            end
            ST_ADDR: if (zero) begin
                load = 1'b1;
                if (fine_c != '0) begin
                    st_d = ST_CSDLY; load_val = fine_c - 1'b1;
                end else if (oed_len != '0) begin
                    st_d = ST_OEDLY; load_val = oed_len - 1'b1;
                end else begin
                    st_d = ST_WAIT; load_val = ws_len - 1'b1;
                end
            end
            ST_CSDLY: if (zero) begin
                load = 1'b1;
                if (oed_len != '0) begin
                    st_d = ST_OEDLY; load_val = oed_len - 1'b1;
                end else begin
                    st_d = ST_WAIT; load_val = ws_len - 1'b1;
                end
            end
            ST_OEDLY: if (zero) begin
                st_d = ST_WAIT; load = 1'b1; load_val = ws_len - 1'b1;
            end
            ST_WAIT: if (zero) begin
                st_d = ST_ACK; load = 1'b1; load_val = '0;
            end
            ST_ACK: begin
                st_d = ST_TURN; load = 1'b1; load_val = PH_C - 1'b1;
            end
            ST_TURN: if (zero) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            attr_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) attr_q <= attr_in;
        end
    end

    always_comb begin
        ale_n = (st_q != ST_ADDR);
        ctl_n = (st_q == ST_IDLE);
        ta_n  = (st_q != ST_ACK);
        oe_n  = !(st_q == ST_WAIT || st_q == ST_ACK);
        cs_n  = !(st_q == ST_OEDLY || st_q == ST_WAIT || st_q == ST_ACK ||
                  (st_q == ST_ADDR && cs_early(attr_q.csd)));
    end

    assign state = st_q;

    p_ale_inside_ctl_r2: assert property (@(posedge clk) disable iff (rst)
        !ale_n |-> !ctl_n);
    p_no_oe_with_ale_r4: assert property (@(posedge clk) disable iff (rst)
        !ale_n |-> oe_n);
    p_ta_single_r5: assert property (@(posedge clk) disable iff (rst)
        !ta_n |=> ta_n);
    p_strobes_together_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |-> $rose(cs_n));
    p_ctl_after_strobes_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_n) |-> (cs_n && oe_n && ale_n));
    p_start_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(ale_n) |-> $past(ctl_n));
endmodule

// File: rtl/lbrd_datapath.sv
module lbrd_datapath
    import lbrd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  lb_state_e     state,
    input  logic          accept,
    input  logic          zero,
    input  logic [DW-1:0] addr_in,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          done,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            if (accept) addr_q <= addr_in;
            if (state == ST_WAIT && zero) data_q <= ad_in;
            done_q <= (state == ST_ACK);
        end
    end

    assign ad_out = addr_q;
    assign ad_oe  = (state == ST_ADDR) || (state == ST_CSDLY) || (state == ST_OEDLY);
    assign done   = done_q;
    assign rdata  = data_q;

    p_addr_steady_r10: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && $past(ad_oe)) |-> $stable(ad_out));
endmodule

// File: rtl/lbrd_read_seq.sv
module lbrd_read_seq
    import lbrd_pkg::*;
#(
    parameter int PHASES = 4,
    parameter int DW     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic [DW-1:0]        addr_i,
    input  logic [CSD_W-1:0]     csd_i,
    input  logic [OED_W-1:0]     oed_i,
    input  logic [WS_W-1:0]      ws_i,
    output logic [DW-1:0]        ad_o,
    output logic                 ad_oe_o,
    input  logic [DW-1:0]        ad_i,
    output logic                 ale_n_o,
    output logic                 cs_n_o,
    output logic                 oe_n_o,
    output logic                 ta_n_o,
    output logic                 ctl_n_o,
    output logic                 done_o,
    output logic [DW-1:0]        rdata_o
);
    localparam int MAX_TICKS = ((1 << WS_W) + (1 << OED_W) + 2) * PHASES;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    lb_state_e     state;
    lb_attr_t      attr_in;
    logic          accept, load, zero;
    logic [CW-1:0] load_val;

    assign attr_in = '{csd: csd_i, oed: oed_i, ws: ws_i};

    lbrd_timer #(.CW(CW)) i_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero(zero)
    );

    lbrd_fsm #(.PHASES(PHASES), .CW(CW)) i_fsm (
        .clk(clk), .rst(rst), .req(req_i), .attr_in(attr_in), .zero(zero),
        .state(state), .accept(accept), .load(load), .load_val(load_val),
        .ale_n(ale_n_o), .cs_n(cs_n_o), .oe_n(oe_n_o), .ta_n(ta_n_o),
        .ctl_n(ctl_n_o)
    );

    lbrd_datapath #(.DW(DW)) i_dp (
        .clk(clk), .rst(rst), .state(state), .accept(accept), .zero(zero),
        .addr_in(addr_i), .ad_in(ad_i), .ad_out(ad_o), .ad_oe(ad_oe_o),
        .done(done_o), .rdata(rdata_o)
    );

    p_bus_released_r4: assert property (@(posedge clk) disable iff (rst)
        !oe_n_o |-> !ad_oe_o);
    p_done_follows_ta_r6: assert property (@(posedge clk) disable iff (rst)
        !ta_n_o |=> done_o);
    p_done_only_after_ta_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(!ta_n_o));
endmodule

// File: tb/test_lbrd_read_seq.sv
module test_lbrd_read_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [DW-1:0] addr = '0;
    logic [1:0] csd = '0;
    logic [1:0] oed = '0;
    logic [3:0] ws  = '0;
    logic [DW-1:0] ad_o, ad_i, rdata;
    logic ad_oe, ale_n, cs_n, oe_n, ta_n, ctl_n, done;
    logic [DW-1:0] cur_addr = '0;

    int vectors = 0;
    int errors  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbrd_read_seq #(.PHASES(PH), .DW(DW)) i_lbrd_read_seq (
        .clk(clk), .rst(rst), .req_i(req), .addr_i(addr), .csd_i(csd),
        .oed_i(oed), .ws_i(ws), .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i),
        .ale_n_o(ale_n), .cs_n_o(cs_n), .oe_n_o(oe_n), .ta_n_o(ta_n),
        .ctl_n_o(ctl_n), .done_o(done), .rdata_o(rdata)
    );

    function automatic logic [DW-1:0] mem_word(logic [DW-1:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    // memory drives only while selected, enabled and not yet acknowledged
    always_comb begin
        if (!cs_n && !oe_n && ta_n) ad_i = mem_word(cur_addr);
        else                        ad_i = 16'hDEAD;
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        check(ale_n == 1'b1, tag, 32'(ale_n), 1);
        check(cs_n  == 1'b1, tag, 32'(cs_n), 1);
        check(oe_n  == 1'b1, tag, 32'(oe_n), 1);
        check(ta_n  == 1'b1, tag, 32'(ta_n), 1);
        check(ctl_n == 1'b1, tag, 32'(ctl_n), 1);
        check(ad_oe == 1'b0, tag, 32'(ad_oe), 0);
        check(done  == 1'b0, tag, 32'(done), 0);
    endtask

    task automatic run_one(input int c, input int o, input int w);
        int fine, t_cs, t_oe, t_ta, t_end, t_idle;
        logic [DW-1:0] a;
        a     = DW'(16'h1000 + c * 97 + o * 31 + w * 7);
        fine  = (c == 2) ? PH / 4 : (c == 3) ? PH / 2 : 0;
        t_cs  = (c >= 2) ? PH + fine : 0;
        t_oe  = PH + fine + o * PH;
        t_ta  = t_oe + (w + 1) * PH;
        t_end = t_ta + 1;
        t_idle = t_end + PH;
        cur_addr = a;
        req  = 1'b1; addr = a;
        csd = 2'(c); oed = 2'(o); ws = 4'(w);
        for (int j = 0; j <= t_idle + 2; j++) begin
            @(negedge clk);
            // R2: latch strobe and bus control
            check(ale_n == !(j < PH), "R2 ale_n", 32'(ale_n), 32'(!(j < PH)));
            // R8 and R9: bus control returns high and stays high
            check(ctl_n == !(j < t_idle), "R8/R9 ctl_n", 32'(ctl_n), 32'(!(j < t_idle)));
            // R3, R7: chip-select placement and release
            check(cs_n == !(j >= t_cs && j < t_end), "R3/R7 cs_n", 32'(cs_n),
                  32'(!(j >= t_cs && j < t_end)));
            // R4, R7: output-enable placement and release
            check(oe_n == !(j >= t_oe && j < t_end), "R4/R7 oe_n", 32'(oe_n),
                  32'(!(j >= t_oe && j < t_end)));
            // R5: single acknowledge tick
            check(ta_n == !(j == t_ta), "R5 ta_n", 32'(ta_n), 32'(!(j == t_ta)));
            // R4: address drive until output-enable
            check(ad_oe == (j < t_oe), "R4 ad_oe", 32'(ad_oe), 32'(j < t_oe));
            if (j < t_oe)
                check(ad_o == a, "R4/R10 ad_o", 32'(ad_o), 32'(a));
            // R6: done pulse and captured data
            check(done == (j == t_end), "R6 done", 32'(done), 32'(j == t_end));
            if (j == t_end)
                check(rdata == mem_word(a), "R6 rdata", 32'(rdata), 32'(mem_word(a)));
            // drive for the following edge
            if (j == 0) req = 1'b0;
            if (j == PH + 1) begin
                req = 1'b1; addr = ~a; csd = ~2'(c); oed = ~2'(o); ws = ~4'(w);
            end
            if (j == t_idle) req = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 after reset");
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 4; o++)
                for (int w = 0; w < 16; w++)
                    run_one(c, o, w);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule